// File: doc/BRIEF.md
# Windowed scalar register index decoder

This block turns the operand fields of a 128-bit instruction bundle into physical scalar register numbers for the first two issue slots. The bundle comes in as four 32-bit words, least significant word first, so bundle bit `n` is bit `n % 32` of word `n / 32`. Each slot yields a destination index, a first-source index and a second-source value. Every index is a 6-bit number that selects one of 64 physical registers, which are seen through a rotating window of 16 architectural names.

Each architectural field is four bits wide: three index bits, and above them one bank bit. The decoder inverts the bank bit and places it at weight 8. When windowing is enabled, it adds eight times the window base and keeps the low six bits of the sum. The second-source output of each slot can instead carry a sign-extended immediate, chosen by a per-slot kind input. The outputs are captured in one register stage and marked valid one cycle after a valid bundle arrives. The format selector in the low nibble of the bundle plays no part.

Top module: `sidx_decode`

## Requirements
- R1: While reset is asserted and until the first valid bundle after reset, `out_valid` is 0 and every index output is 0. Reset asserts asynchronously and is released in step with the clock two cycles after `rst_n` rises.
- R2: `out_valid` equals `in_valid` delayed by one cycle. The index and source outputs load only in a cycle with `in_valid` high, and hold their values otherwise.
- R3: With windowing off, a field with index bits `i` and bank bit `b` decodes to `(!b)*8 + i`.
- R4: With `win_en` high, the decoded value is `((!b)*8 + i + 8*win_base) mod 64`, so sums above 63 wrap.
- R5: With `win_en` low, `win_base` has no effect on any output.
- R6: Slot 0 uses bits 14:12 with bank bit 15 for the destination, bits 10:8 with bank bit 11 for source 1, and bits 6:4 with bank bit 7 for source 2.
- R7: Slot 1 uses bits 18:16 with bank bit 19 for source 1 and bits 22:20 with bank bit 23 for source 2. Its destination uses bits 62:60 with bank bit 63.
- R8: Kind value 0 puts the source-2 register index on `sN_src2`, zero-extended to 32 bits. Kind value 1 puts an 8-bit two's-complement immediate there, sign-extended to 32 bits. For slot 0 the immediate is {bits 88:85, bits 7:4}, with bit 88 as the sign. For slot 1 it is {bits 95:92, bits 23:20}, with bit 95 as the sign.
- R9: Bundle bits 3:0 affect no output.
- R10: The kind inputs of the two slots act independently. Each one selects only the source-2 output of its own slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Bundle words are valid this cycle |
| bundle_w0 | input | 32 | Bundle bits 31:0 |
| bundle_w1 | input | 32 | Bundle bits 63:32 |
| bundle_w2 | input | 32 | Bundle bits 95:64 |
| bundle_w3 | input | 32 | Bundle bits 127:96 |
| win_en | input | 1 | Enables window rotation |
| win_base | input | 3 | Window base, weighted by 8 |
| kind_s0 | input | 1 | Slot 0 source-2 kind: 0 register, 1 immediate |
| kind_s1 | input | 1 | Slot 1 source-2 kind: 0 register, 1 immediate |
| out_valid | output | 1 | Outputs carry a decoded bundle |
| s0_dst | output | 6 | Slot 0 physical destination |
| s0_src1 | output | 6 | Slot 0 physical source 1 |
| s0_src2 | output | 32 | Slot 0 source 2 index or immediate |
| s1_dst | output | 6 | Slot 1 physical destination |
| s1_src1 | output | 6 | Slot 1 physical source 1 |
| s1_src2 | output | 32 | Slot 1 source 2 index or immediate |

## Verification
Window wrap-around and immediate selection can fall in the same cycle. In one bundle, a slot can have a destination whose rotated sum passes 63 while its source-2 lane carries an immediate whose low nibble shares bits with that slot's register field. Vectors with the window base at 7, mixed kinds and negative immediates provoke this case. The bench then judges the wrapped destination and the sign-extended immediate against values computed by hand for the same bundle, and checks that the other slot keeps its register index.

// File: rtl/sidx_pkg.sv
package sidx_pkg;
  localparam int IDX_W     = 3;
  localparam int PHYS_W    = 6;
  localparam int DATA_W    = 32;
  localparam int BUNDLE_W  = 128;
  localparam int NUM_SLOTS = 2;
  localparam int NUM_ROLES = 3;
  localparam int IMM_CHUNK = 4;

  localparam int ROLE_DST  = 0;
  localparam int ROLE_SRC1 = 1;
  localparam int ROLE_SRC2 = 2;

  // Lowest index bit of an architectural field; its bank bit sits IDX_W above.
  function automatic int field_lsb(input int slot, input int role);
    int pos;
    pos = 4;
    if (slot == 0) begin
      case (role)
        ROLE_DST:  pos = 12;
        ROLE_SRC1: pos = 8;
        default:   pos = 4;
      endcase
    end else begin
      case (role)
        ROLE_DST:  pos = 60;
        ROLE_SRC1: pos = 16;
        default:   pos = 20;
      endcase
    end
    return pos;
  endfunction

  // Lowest bit of the upper immediate chunk; its top bit is the sign.
  function automatic int imm_hi_lsb(input int slot);
    return (slot == 0) ? 85 : 92;
  endfunction
endpackage

// File: rtl/sidx_rst_sync.sv
module sidx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/sidx_winoff.sv
module sidx_winoff #(
  parameter int IDX_W  = 3,
  parameter int PHYS_W = 6,
  localparam int WB_W  = PHYS_W - IDX_W
) (
  input  logic              win_en,
  input  logic [WB_W-1:0]   win_base,
  output logic [PHYS_W-1:0] win_off
);
  // Base times eight; forced to zero outside windowed mode.
  always_comb begin
    if (win_en) begin
      win_off = {win_base, {IDX_W{1'b0}}};
    end else begin
      win_off = '0;
    end
  end
endmodule

// File: rtl/sidx_field.sv
module sidx_field #(
  parameter int IDX_W  = 3,
  parameter int PHYS_W = 6,
  localparam int PAD_W = PHYS_W - IDX_W - 1
) (
  input  logic [IDX_W-1:0]  idx_bits,
  input  logic              bank_bit,
  input  logic [PHYS_W-1:0] win_off,
  output logic [PHYS_W-1:0] phys_idx
);
  logic [PHYS_W-1:0] arch_idx;

  // Inverted bank bit lands just above the index bits.
  assign arch_idx = {{PAD_W{1'b0}}, ~bank_bit, idx_bits};
  // Sum truncates to PHYS_W bits, which is the wrap.
  assign phys_idx = arch_idx + win_off;
endmodule

// File: rtl/sidx_imm.sv
module sidx_imm #(
  parameter int CHUNK_W = 4,
  parameter int OUT_W   = 32,
  localparam int EXT_W  = OUT_W - 2 * CHUNK_W
) (
  input  logic [CHUNK_W-1:0] hi_chunk,
  input  logic [CHUNK_W-1:0] lo_chunk,
  output logic [OUT_W-1:0]   imm_val
);
  assign imm_val = {{EXT_W{hi_chunk[CHUNK_W-1]}}, hi_chunk, lo_chunk};
endmodule

// File: rtl/sidx_decode.sv
module sidx_decode #(
  parameter int PHYS_W = sidx_pkg::PHYS_W,
  parameter int DATA_W = sidx_pkg::DATA_W,
  localparam int WB_W  = PHYS_W - sidx_pkg::IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       bundle_w0,
  input  logic [31:0]       bundle_w1,
  input  logic [31:0]       bundle_w2,
  input  logic [31:0]       bundle_w3,
  input  logic              win_en,
  input  logic [WB_W-1:0]   win_base,
  input  logic              kind_s0,
  input  logic              kind_s1,
  output logic              out_valid,
  output logic [PHYS_W-1:0] s0_dst,
  output logic [PHYS_W-1:0] s0_src1,
  output logic [DATA_W-1:0] s0_src2,
  output logic [PHYS_W-1:0] s1_dst,
  output logic [PHYS_W-1:0] s1_src1,
  output logic [DATA_W-1:0] s1_src2
);
  import sidx_pkg::*;

  localparam int ZPAD_W = DATA_W - PHYS_W;

  logic                  rst_core_n;
  logic [BUNDLE_W-1:0]   bundle;
  logic                  unused_bundle;
  logic [PHYS_W-1:0]     win_off;
  logic [NUM_SLOTS-1:0]  kind;

  logic [NUM_SLOTS-1:0][NUM_ROLES-1:0][PHYS_W-1:0] phys_d;
  logic [NUM_SLOTS-1:0][DATA_W-1:0]                imm_d;

  // Next-state and register copies of the slot outputs.
  logic [NUM_SLOTS-1:0][PHYS_W-1:0] dst_n, dst_q;
  logic [NUM_SLOTS-1:0][PHYS_W-1:0] src1_n, src1_q;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] src2_n, src2_q;
  logic                             vld_n, vld_q;
  logic                             load_en;

  sidx_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  assign bundle        = {bundle_w3, bundle_w2, bundle_w1, bundle_w0};
  assign unused_bundle = ^bundle;
  assign kind          = {kind_s1, kind_s0};

  sidx_winoff #(
    .IDX_W  (IDX_W),
    .PHYS_W (PHYS_W)
  ) u_winoff (
    .win_en   (win_en),
    .win_base (win_base),
    .win_off  (win_off)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    for (genvar r = 0; r < NUM_ROLES; r++) begin : g_role
      localparam int LSB = field_lsb(s, r);
      sidx_field #(
        .IDX_W  (IDX_W),
        .PHYS_W (PHYS_W)
      ) u_field (
        .idx_bits (bundle[LSB +: IDX_W]),
        .bank_bit (bundle[LSB + IDX_W]),
        .win_off  (win_off),
        .phys_idx (phys_d[s][r])
      );
    end

    localparam int LO_LSB = field_lsb(s, ROLE_SRC2);
    localparam int HI_LSB = imm_hi_lsb(s);
    sidx_imm #(
      .CHUNK_W (IMM_CHUNK),
      .OUT_W   (DATA_W)
    ) u_imm (
      .hi_chunk (bundle[HI_LSB +: IMM_CHUNK]),
      .lo_chunk (bundle[LO_LSB +: IMM_CHUNK]),
      .imm_val  (imm_d[s])
    );
  end

  // Next-state logic.
  assign load_en = in_valid;

  always_comb begin
    vld_n = in_valid;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      dst_n[s]  = phys_d[s][ROLE_DST];
      src1_n[s] = phys_d[s][ROLE_SRC1];
      if (kind[s]) begin
        src2_n[s] = imm_d[s];
      end else begin
        src2_n[s] = {{ZPAD_W{1'b0}}, phys_d[s][ROLE_SRC2]};
      end
    end
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_n;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      dst_q  <= '0;
      src1_q <= '0;
      src2_q <= '0;
    end else if (load_en) begin
      dst_q  <= dst_n;
      src1_q <= src1_n;
      src2_q <= src2_n;
    end
  end

  assign out_valid = vld_q;
  assign s0_dst    = dst_q[0];
  assign s0_src1   = src1_q[0];
  assign s0_src2   = src2_q[0];
  assign s1_dst    = dst_q[1];
  assign s1_src1   = src1_q[1];
  assign s1_src2   = src2_q[1];
endmodule

// File: rtl/sidx_checker.sv
module sidx_checker #(
  parameter int PHYS_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              in_valid,
  input logic              win_en,
  input logic              kind_s0,
  input logic              kind_s1,
  input logic              dst_bank_s0,
  input logic              out_valid,
  input logic [PHYS_W-1:0] s0_dst,
  input logic [PHYS_W-1:0] s1_dst,
  input logic [DATA_W-1:0] s0_src2,
  input logic [DATA_W-1:0] s1_src2
);
  // R2: valid is the input valid one cycle later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_core_n)
    in_valid |=> out_valid);
  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_core_n)
    !in_valid |=> !out_valid);
  // R2: outputs hold without a valid bundle
  a_r2_hold_data: assert property (@(posedge clk) disable iff (!rst_core_n)
    !in_valid |=> ($stable(s0_dst) && $stable(s1_dst) && $stable(s0_src2) && $stable(s1_src2)));
  // R5: no rotation keeps indices in the low 16
  a_r5_no_rotation: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_valid && !win_en) |=> (s0_dst[PHYS_W-1:4] == '0 && s1_dst[PHYS_W-1:4] == '0));
  // R3: bank bit appears inverted at weight 8
  a_r3_bank_inverted: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_valid && !win_en) |=> (s0_dst[3] == !$past(dst_bank_s0)));
  // R8: immediate upper bits are copies of the sign
  a_r8_imm_signext: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_valid && kind_s0) |=> (s0_src2[DATA_W-1:7] == '0 || s0_src2[DATA_W-1:7] == '1));
  // R8: register index is zero-extended
  a_r8_reg_zext: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_valid && !kind_s1) |=> (s1_src2[DATA_W-1:PHYS_W] == '0));
endmodule

bind sidx_decode sidx_checker #(
  .PHYS_W (PHYS_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .in_valid    (in_valid),
  .win_en      (win_en),
  .kind_s0     (kind_s0),
  .kind_s1     (kind_s1),
  .dst_bank_s0 (bundle_w0[15]),
  .out_valid   (out_valid),
  .s0_dst      (s0_dst),
  .s1_dst      (s1_dst),
  .s0_src2     (s0_src2),
  .s1_src2     (s1_src2)
);

// File: tb/sidx_decode_tb_top.sv
`timescale 1ns/1ps
module sidx_decode_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] w0, w1, w2, w3;
  logic        win_en;
  logic [2:0]  win_base;
  logic        kind_s0, kind_s1;
  logic        out_valid;
  logic [5:0]  s0_dst, s0_src1, s1_dst, s1_src1;
  logic [31:0] s0_src2, s1_src2;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  sidx_decode dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .bundle_w0 (w0),
    .bundle_w1 (w1),
    .bundle_w2 (w2),
    .bundle_w3 (w3),
    .win_en    (win_en),
    .win_base  (win_base),
    .kind_s0   (kind_s0),
    .kind_s1   (kind_s1),
    .out_valid (out_valid),
    .s0_dst    (s0_dst),
    .s0_src1   (s0_src1),
    .s0_src2   (s0_src2),
    .s1_dst    (s1_dst),
    .s1_src1   (s1_src1),
    .s1_src2   (s1_src2)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [31:0] v_w0;
    logic [31:0] v_w1;
    logic [31:0] v_w2;
    logic        v_en;
    logic [2:0]  v_base;
    logic        v_k0;
    logic        v_k1;
    logic [5:0]  e_s0_dst;
    logic [5:0]  e_s1_dst;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 3'd0, 1'b0, 1'b0, 6'd8,  6'd8},
    '{32'h0000_F000, 32'hF000_0000, 32'h0000_0000, 1'b0, 3'd0, 1'b0, 1'b0, 6'd7,  6'd7},
    '{32'h0000_F000, 32'hF000_0000, 32'h0000_0000, 1'b1, 3'd2, 1'b0, 1'b0, 6'd23, 6'd23},
    '{32'h0000_7000, 32'h7000_0000, 32'h0000_0000, 1'b1, 3'd7, 1'b1, 1'b0, 6'd7,  6'd7},
    '{32'h00A5_5ED0, 32'h9000_0000, 32'h0120_0000, 1'b1, 3'd3, 1'b1, 1'b1, 6'd37, 6'd25},
    '{32'h0000_3000, 32'h3000_0000, 32'h0000_0000, 1'b0, 3'd5, 1'b0, 1'b1, 6'd11, 6'd11}
  };

  function automatic logic [5:0] m_phys(input logic [2:0] idx, input logic bank,
                                         input logic en, input logic [2:0] base);
    logic [5:0] a;
    logic [5:0] off;
    a   = {2'b00, ~bank, idx};
    off = en ? {base, 3'b000} : 6'd0;
    return a + off;
  endfunction

  function automatic logic [31:0] m_imm(input logic [3:0] hi, input logic [3:0] lo);
    return {{24{hi[3]}}, hi, lo};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected non-table outputs from the field positions in R6, R7, R8.
  task automatic chk_model(input string tag, input logic [31:0] a0, input logic [31:0] a1,
                           input logic [31:0] a2, input logic en, input logic [2:0] base,
                           input logic k0, input logic k1);
    logic [127:0] b;
    logic [31:0]  e2_0, e2_1;
    b = {32'h0, a2, a1, a0};
    chk({tag, " R6 s0_src1"}, {26'b0, s0_src1}, {26'b0, m_phys(b[10:8], b[11], en, base)});
    chk({tag, " R7 s1_src1"}, {26'b0, s1_src1}, {26'b0, m_phys(b[18:16], b[19], en, base)});
    e2_0 = k0 ? m_imm(b[88:85], b[7:4])   : {26'b0, m_phys(b[6:4], b[7], en, base)};
    e2_1 = k1 ? m_imm(b[95:92], b[23:20]) : {26'b0, m_phys(b[22:20], b[23], en, base)};
    chk({tag, " R8 R10 s0_src2"}, s0_src2, e2_0);
    chk({tag, " R8 R10 s1_src2"}, s1_src2, e2_1);
  endtask

  task automatic apply(input logic [31:0] a0, input logic [31:0] a1, input logic [31:0] a2,
                       input logic en, input logic [2:0] base, input logic k0, input logic k1);
    @(negedge clk);
    w0 = a0; w1 = a1; w2 = a2;
    win_en = en; win_base = base; kind_s0 = k0; kind_s1 = k1;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep0, keep1;
    rst_n = 1'b0; in_valid = 1'b0;
    w0 = '0; w1 = '0; w2 = '0; w3 = 32'hDEAD_BEEF;
    win_en = 1'b0; win_base = 3'd0; kind_s0 = 1'b0; kind_s1 = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out_valid in reset", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 out_valid after release", {31'b0, out_valid}, 32'd0);
    chk("R1 s0_dst after release", {26'b0, s0_dst}, 32'd0);
    chk("R1 s1_src2 after release", s1_src2, 32'd0);

    // Table walk: R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].v_w0, VECS[i].v_w1, VECS[i].v_w2, VECS[i].v_en, VECS[i].v_base,
            VECS[i].v_k0, VECS[i].v_k1);
      chk("R2 out_valid", {31'b0, out_valid}, 32'd1);
      chk("R3 R4 R6 s0_dst", {26'b0, s0_dst}, {26'b0, VECS[i].e_s0_dst});
      chk("R3 R4 R7 s1_dst", {26'b0, s1_dst}, {26'b0, VECS[i].e_s1_dst});
      chk_model("table", VECS[i].v_w0, VECS[i].v_w1, VECS[i].v_w2, VECS[i].v_en,
                VECS[i].v_base, VECS[i].v_k0, VECS[i].v_k1);
    end

    // R2: valid drops and data holds with in_valid low
    keep0 = s0_src2; keep1 = s1_src2;
    w0 = 32'hFFFF_FFFF; w1 = 32'h0; w2 = 32'h8000_0000; win_en = 1'b1; win_base = 3'd6;
    @(negedge clk);
    @(negedge clk);
    chk("R2 out_valid low", {31'b0, out_valid}, 32'd0);
    chk("R2 s0_dst held", {26'b0, s0_dst}, 32'd11);
    chk("R2 s1_dst held", {26'b0, s1_dst}, 32'd11);
    chk("R2 s0_src2 held", s0_src2, keep0);
    chk("R2 s1_src2 held", s1_src2, keep1);

    // R8 R10: negative slot-0 immediate, positive slot-1 immediate
    apply(32'h00F0_0000, 32'h0, 32'h7100_0000, 1'b0, 3'd0, 1'b1, 1'b1);
    chk("R8 s0 imm -128", s0_src2, 32'hFFFF_FF80);
    chk("R8 s1 imm +127", s1_src2, 32'h0000_007F);
    // R10: slot 1 back to register while slot 0 stays immediate
    apply(32'h00F0_0000, 32'h0, 32'h7100_0000, 1'b0, 3'd0, 1'b1, 1'b0);
    chk("R10 s0 imm kept", s0_src2, 32'hFFFF_FF80);
    chk("R10 s1 reg index", s1_src2, 32'd7);

    // R4 with R8: destination wraps while slot-0 lane carries an immediate
    apply(32'h0000_70F0, 32'h7000_0000, 32'h0100_0000, 1'b1, 3'd7, 1'b1, 1'b0);
    chk("R4 wrap s0_dst", {26'b0, s0_dst}, 32'd7);
    chk("R8 imm during wrap", s0_src2, 32'hFFFF_FF8F);

    // R5: window base ignored with windowing off
    apply(32'h0000_3000, 32'h0, 32'h0, 1'b0, 3'd7, 1'b0, 1'b0);
    chk("R5 base ignored s0_dst", {26'b0, s0_dst}, 32'd11);
    chk("R5 base ignored s1_dst", {26'b0, s1_dst}, 32'd8);

    // R9: low nibble changes nothing
    apply(32'h00A5_5ED0, 32'h9000_0000, 32'h0120_0000, 1'b1, 3'd3, 1'b1, 1'b1);
    keep0 = s0_src2; keep1 = {20'b0, s0_dst, s1_dst};
    apply(32'h00A5_5EDF, 32'h9000_0000, 32'h0120_0000, 1'b1, 3'd3, 1'b1, 1'b1);
    chk("R9 s0_src2 unaffected", s0_src2, keep0);
    chk("R9 dsts unaffected", {20'b0, s0_dst, s1_dst}, keep1);
    chk_model("R9", 32'h00A5_5ED0, 32'h9000_0000, 32'h0120_0000, 1'b1, 3'd3, 1'b1, 1'b1);

    // R1: asynchronous reset mid-run
    apply(32'h0000_F000, 32'h0, 32'h0, 1'b0, 3'd0, 1'b0, 1'b0);
    #1 rst_n = 1'b0;
    #1;
    chk("R1 async reset valid", {31'b0, out_valid}, 32'd0);
    chk("R1 async reset s0_dst", {26'b0, s0_dst}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule